// File: doc/BRIEF.md
# SMBus Host Command Sequencer

This block sits between a host that wants to run one SMBus transaction and a byte-level I2C master that knows only five primitives: start with an address and direction, send one byte, receive one byte, answer a received byte with a NACK, and stop. The host presents a request with a command type, a 7-bit target address, a command code, up to 16 bits of write data, a block length and two flags. The sequencer then issues the matching series of primitives, one at a time, and waits for the master to complete each one. When the series is over it pulses `done` for one cycle, with `fail` beside it.

Every SMBus command format is covered: quick, send byte, receive byte, byte and word write and read, and block write and read. Word data travels low byte first in both directions. A block write takes its bytes from the caller's buffer through a read port and is limited to `MAX_BLK` bytes. A block read stores bytes through a write port. It can leave out the command phase, and it can take its count either from the first byte it receives or from the caller. A received count larger than the caller's capacity becomes zero. A missing acknowledge on the first start ends the transaction at once with failure. A missing acknowledge on the repeated read start closes the bus with a stop and then reports failure.

Top module: `smbus_cmd_seq`

## Requirements
- R1: A request is taken only in a cycle where `busy` is low and `req_valid` is high. `busy` is high from the next cycle until the cycle after `done`. `done` lasts exactly one cycle. A `req_valid` seen while `busy` is high has no effect on the transaction in progress.
- R2: `op_kind` encodes START=0, SEND=1, RECV=2, NACK=3, STOP=4. The fields `op_valid`, `op_kind`, `op_rw` and `op_wdata` stay unchanged until the cycle in which `op_done` is high. `op_ack` is read only on a START, with 1 meaning acknowledged. `req_cmd` encodes quick=0, send byte=1, receive byte=2, write byte=3, read byte=4, write word=5, read word=6, write block=7, read block=8.
- R3: A quick command issues START(`req_addr`, `req_rw`) followed by STOP, with no data phase.
- R4: If the first START of any command is not acknowledged, the transaction ends with `fail`=1, and no further operation is issued, not even a STOP.
- R5: Send byte issues START(write), SEND(`req_code`), STOP.
- R6: Receive byte issues START(read), RECV, NACK, STOP. `rd_data` then holds the received byte in bits 7:0 with zeros above, and `rd_len`=1.
- R7: Write byte issues START(write), SEND code, SEND `req_wdata[7:0]`, STOP. Write word issues the same with SEND `req_wdata[15:8]` added after the low byte.
- R8: Read byte and read word issue START(write), SEND code, START(read), then one or two RECVs, then NACK and STOP. For a word, `rd_data` = first byte | second byte << 8. `rd_len` counts the data bytes received.
- R9: If the repeated read START is not acknowledged, a STOP is issued and the transaction ends with `fail`=1.
- R10: Block write uses count n = min(`req_len`, `MAX_BLK`). It issues START(write), SEND code, and SEND n only if `req_len_byte`=1. It then sends buffer bytes 0..n-1 in order, read through `buf_rd_idx`, and ends with STOP.
- R11: Block read issues START(write) and SEND code only if `req_cmd_phase`=1, then START(read). The count comes from the first RECV if `req_len_byte`=1, and from `req_len` otherwise. NACK and STOP always close the transaction, even when the count is zero.
- R12: In a block read, a received count greater than `req_len` is replaced by 0. Data byte i is written to buffer index i through `buf_wr_en`. No index at or beyond the count is written. `rd_len` reports the count read. `rd_data` and `rd_len` are cleared when a request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_cmd | input | 4 | Command type (encoding in R2) |
| req_addr | input | 7 | Target address |
| req_rw | input | 1 | Direction for a quick command (1 = read) |
| req_code | input | 8 | Command code, or the data byte of send byte |
| req_wdata | input | 16 | Write data for byte and word writes |
| req_len | input | LEN_W | Block write length or block read capacity |
| req_len_byte | input | 1 | Block: send or receive a count byte |
| req_cmd_phase | input | 1 | Block read: issue the command phase |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Failure status, valid with done |
| rd_data | output | 16 | Received byte or word |
| rd_len | output | LEN_W | Number of data bytes received |
| op_valid | output | 1 | Primitive request to the byte master |
| op_kind | output | 3 | Primitive type |
| op_addr | output | 7 | Address for START |
| op_rw | output | 1 | Direction for START |
| op_wdata | output | 8 | Byte for SEND |
| op_done | input | 1 | Primitive complete |
| op_ack | input | 1 | Address acknowledge for START |
| op_rdata | input | 8 | Byte returned by RECV |
| buf_rd_idx | output | LEN_W | Block write buffer index |
| buf_rd_data | input | 8 | Block write buffer byte |
| buf_wr_en | output | 1 | Block read buffer write strobe |
| buf_wr_idx | output | LEN_W | Block read buffer index |
| buf_wr_data | output | 8 | Block read buffer byte |

## Verification
The bench builds the sequencer with `MAX_BLK`=4, which gives a 3-bit length. With that size, every requested length from 0 to 7 can be swept. The sweep covers both sides of the write clamp, and every received count from 0 to 7 against every capacity, so zeroing an over-large count is exercised at each boundary. Each command also runs with both acknowledge outcomes on each START, and one run raises a second request while busy.

// File: rtl/smbus_seq_pkg.sv
// Shared encodings for the SMBus host command sequencer.
// Assumes: the byte master decodes op kinds with exactly these values.
package smbus_seq_pkg;

    typedef enum logic [3:0] {
        CMD_QUICK     = 4'd0,
        CMD_SEND_BYTE = 4'd1,
        CMD_RECV_BYTE = 4'd2,
        CMD_WR_BYTE   = 4'd3,
        CMD_RD_BYTE   = 4'd4,
        CMD_WR_WORD   = 4'd5,
        CMD_RD_WORD   = 4'd6,
        CMD_WR_BLOCK  = 4'd7,
        CMD_RD_BLOCK  = 4'd8
    } smb_cmd_e;

    typedef enum logic [2:0] {
        OP_START = 3'd0,
        OP_SEND  = 3'd1,
        OP_RECV  = 3'd2,
        OP_NACK  = 3'd3,
        OP_STOP  = 3'd4
    } bus_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START_A,
        ST_SEND_CODE,
        ST_SEND_LEN,
        ST_SEND_DATA,
        ST_START_R,
        ST_RECV_LEN,
        ST_RECV_DATA,
        ST_NACK,
        ST_STOP,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/smbus_seq_len.sv
// Length arithmetic for block transfers.
// Computes the clamped block write count, and the block read count
// taken from a received length byte (0 when it exceeds capacity).
// Assumes: purely combinational; the caller latches what it needs.
module smbus_seq_len #(
    parameter int MAX_BLK = 32,
    parameter int LEN_W   = 6
) (
    input  logic [LEN_W-1:0] req_len,
    input  logic [LEN_W-1:0] cap,
    input  logic [7:0]       rx_byte,
    output logic [LEN_W-1:0] wr_count,
    output logic [LEN_W-1:0] rx_count
);

    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_BLK);

    logic [15:0] cap_ext;
    logic [15:0] rx_ext;

    // Clamp the requested write length to the block limit.
    always_comb begin
        wr_count = (req_len > MAX_L) ? MAX_L : req_len;
    end

    // Replace a received count larger than the capacity with zero.
    always_comb begin
        cap_ext  = 16'(cap);
        rx_ext   = 16'(rx_byte);
        rx_count = (rx_ext > cap_ext) ? '0 : LEN_W'(rx_byte);
    end

endmodule

// File: rtl/smbus_seq_rdata.sv
// Read data assembler: places received bytes low byte first.
// Assumes: idx 0 is the first received data byte, idx 1 the second.
module smbus_seq_rdata (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        wr_en,
    input  logic        idx,
    input  logic [7:0]  byte_in,
    output logic [15:0] rd_data
);

    // Clear on a new request, otherwise store a byte in its lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (clr) begin
            rd_data <= '0;
        end else if (wr_en) begin
            if (idx) begin
                rd_data[15:8] <= byte_in;
            end else begin
                rd_data[7:0] <= byte_in;
            end
        end
    end

endmodule

// File: rtl/smbus_seq_ctrl.sv
// Transaction controller: walks one SMBus command through the
// byte-level primitives, one outstanding primitive at a time.
// Assumes: the master answers each held op with a one-cycle op_done;
// op_ack is meaningful only for START.
module smbus_seq_ctrl
    import smbus_seq_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       req_cmd,
    input  logic [6:0]       req_addr,
    input  logic             req_rw,
    input  logic [7:0]       req_code,
    input  logic [15:0]      req_wdata,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_len_byte,
    input  logic             req_cmd_phase,
    input  logic [LEN_W-1:0] wr_count,
    input  logic [LEN_W-1:0] rx_count,
    output logic [LEN_W-1:0] cap,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [LEN_W-1:0] rd_len,
    output logic             rd_clr,
    output logic             rd_wr_en,
    output logic             rd_idx,
    output logic             op_valid,
    output logic [2:0]       op_kind,
    output logic [6:0]       op_addr,
    output logic             op_rw,
    output logic [7:0]       op_wdata,
    input  logic             op_done,
    input  logic             op_ack,
    input  logic [7:0]       op_rdata,
    output logic [LEN_W-1:0] buf_rd_idx,
    input  logic [7:0]       buf_rd_data,
    output logic             buf_wr_en,
    output logic [LEN_W-1:0] buf_wr_idx,
    output logic [7:0]       buf_wr_data
);

    localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO_L = LEN_W'(2);

    seq_state_e       state;
    smb_cmd_e         cmd_q;
    logic [6:0]       addr_q;
    logic             rw_q;
    logic [7:0]       code_q;
    logic [15:0]      wdata_q;
    logic [LEN_W-1:0] cap_q;
    logic [LEN_W-1:0] count_q;
    logic [LEN_W-1:0] idx_q;
    logic [LEN_W-1:0] rxn_q;
    logic             fail_q;
    logic             lflag_q;
    logic             cph_q;

    logic [LEN_W-1:0] idx_nx;
    logic [LEN_W-1:0] init_count;
    logic             first_read;
    logic             first_rw;
    seq_state_e       rb_state;
    logic [LEN_W-1:0] rb_count;
    seq_state_e       code_next;
    logic             accept;

    assign accept = (state == ST_IDLE) && req_valid;
    assign idx_nx = idx_q + ONE_L;
    assign cap    = cap_q;

    // Data byte count known at acceptance (writes only).
    always_comb begin
        case (smb_cmd_e'(req_cmd))
            CMD_WR_BYTE:  init_count = ONE_L;
            CMD_WR_WORD:  init_count = TWO_L;
            CMD_WR_BLOCK: init_count = wr_count;
            default:      init_count = '0;
        endcase
    end

    // Direction of the first START.
    always_comb begin
        first_read = (cmd_q == CMD_RECV_BYTE) ||
                     ((cmd_q == CMD_RD_BLOCK) && !cph_q);
        first_rw   = (cmd_q == CMD_QUICK) ? rw_q : first_read;
    end

    // Where to go once a read-direction START is acknowledged.
    always_comb begin
        rb_state = ST_RECV_DATA;
        rb_count = ONE_L;
        case (cmd_q)
            CMD_RD_WORD: rb_count = TWO_L;
            CMD_RD_BLOCK: begin
                if (lflag_q) begin
                    rb_state = ST_RECV_LEN;
                    rb_count = '0;
                end else begin
                    rb_count = cap_q;
                    rb_state = (cap_q == '0) ? ST_NACK : ST_RECV_DATA;
                end
            end
            default: ;
        endcase
    end

    // Where to go after the command code byte.
    always_comb begin
        case (cmd_q)
            CMD_WR_BYTE, CMD_WR_WORD:
                code_next = ST_SEND_DATA;
            CMD_WR_BLOCK:
                code_next = lflag_q ? ST_SEND_LEN :
                            ((count_q == '0) ? ST_STOP : ST_SEND_DATA);
            CMD_RD_BYTE, CMD_RD_WORD, CMD_RD_BLOCK:
                code_next = ST_START_R;
            default:
                code_next = ST_STOP;
        endcase
    end

    // Main sequencing register set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cmd_q   <= CMD_QUICK;
            addr_q  <= '0;
            rw_q    <= 1'b0;
            code_q  <= '0;
            wdata_q <= '0;
            cap_q   <= '0;
            count_q <= '0;
            idx_q   <= '0;
            rxn_q   <= '0;
            fail_q  <= 1'b0;
            lflag_q <= 1'b0;
            cph_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cmd_q   <= smb_cmd_e'(req_cmd);
                        addr_q  <= req_addr;
                        rw_q    <= req_rw;
                        code_q  <= req_code;
                        wdata_q <= req_wdata;
                        cap_q   <= req_len;
                        count_q <= init_count;
                        idx_q   <= '0;
                        rxn_q   <= '0;
                        fail_q  <= 1'b0;
                        lflag_q <= req_len_byte;
                        cph_q   <= req_cmd_phase;
                        state   <= ST_START_A;
                    end
                end
                ST_START_A: begin
                    if (op_done) begin
                        if (!op_ack) begin
                            fail_q <= 1'b1;
                            state  <= ST_FINISH;
                        end else if (cmd_q == CMD_QUICK) begin
                            state <= ST_STOP;
                        end else if (first_read) begin
                            state   <= rb_state;
                            count_q <= rb_count;
                            idx_q   <= '0;
                        end else begin
                            state <= ST_SEND_CODE;
                        end
                    end
                end
                ST_SEND_CODE: begin
                    if (op_done) state <= code_next;
                end
                ST_SEND_LEN: begin
                    if (op_done) state <= (count_q == '0) ? ST_STOP : ST_SEND_DATA;
                end
                ST_SEND_DATA: begin
                    if (op_done) begin
                        idx_q <= idx_nx;
                        if (idx_nx == count_q) state <= ST_STOP;
                    end
                end
                ST_START_R: begin
                    if (op_done) begin
                        if (!op_ack) begin
                            fail_q <= 1'b1;
                            state  <= ST_STOP;
                        end else begin
                            state   <= rb_state;
                            count_q <= rb_count;
                            idx_q   <= '0;
                        end
                    end
                end
                ST_RECV_LEN: begin
                    if (op_done) begin
                        count_q <= rx_count;
                        idx_q   <= '0;
                        state   <= (rx_count == '0) ? ST_NACK : ST_RECV_DATA;
                    end
                end
                ST_RECV_DATA: begin
                    if (op_done) begin
                        idx_q <= idx_nx;
                        rxn_q <= rxn_q + ONE_L;
                        if (idx_nx == count_q) state <= ST_NACK;
                    end
                end
                ST_NACK: begin
                    if (op_done) state <= ST_STOP;
                end
                ST_STOP: begin
                    if (op_done) state <= ST_FINISH;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Primitive presented to the byte master in each state.
    always_comb begin
        op_valid = 1'b1;
        op_kind  = OP_STOP;
        op_rw    = 1'b0;
        op_wdata = 8'h00;
        case (state)
            ST_START_A: begin
                op_kind = OP_START;
                op_rw   = first_rw;
            end
            ST_START_R: begin
                op_kind = OP_START;
                op_rw   = 1'b1;
            end
            ST_SEND_CODE: begin
                op_kind  = OP_SEND;
                op_wdata = code_q;
            end
            ST_SEND_LEN: begin
                op_kind  = OP_SEND;
                op_wdata = 8'(count_q);
            end
            ST_SEND_DATA: begin
                op_kind = OP_SEND;
                if (cmd_q == CMD_WR_BLOCK) begin
                    op_wdata = buf_rd_data;
                end else begin
                    op_wdata = idx_q[0] ? wdata_q[15:8] : wdata_q[7:0];
                end
            end
            ST_RECV_LEN, ST_RECV_DATA: op_kind = OP_RECV;
            ST_NACK:                   op_kind = OP_NACK;
            ST_STOP:                   op_kind = OP_STOP;
            default:                   op_valid = 1'b0;
        endcase
    end

    // Status, buffer and assembler strobes.
    always_comb begin
        op_addr     = addr_q;
        busy        = (state != ST_IDLE);
        done        = (state == ST_FINISH);
        fail        = done && fail_q;
        rd_len      = rxn_q;
        rd_clr      = accept;
        rd_wr_en    = (state == ST_RECV_DATA) && op_done && (cmd_q != CMD_RD_BLOCK);
        rd_idx      = idx_q[0];
        buf_rd_idx  = idx_q;
        buf_wr_en   = (state == ST_RECV_DATA) && op_done && (cmd_q == CMD_RD_BLOCK);
        buf_wr_idx  = idx_q;
        buf_wr_data = op_rdata;
    end

endmodule

// File: rtl/smbus_cmd_seq.sv
// SMBus host command sequencer top level.
// Expands one request into START/SEND/RECV/NACK/STOP primitives for a
// byte-level I2C master and reports read data, count and failure.
// Assumes: synchronous active-low reset; MAX_BLK >= 2.
module smbus_cmd_seq #(
    parameter int MAX_BLK = 32,
    localparam int LEN_W  = $clog2(MAX_BLK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       req_cmd,
    input  logic [6:0]       req_addr,
    input  logic             req_rw,
    input  logic [7:0]       req_code,
    input  logic [15:0]      req_wdata,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_len_byte,
    input  logic             req_cmd_phase,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [15:0]      rd_data,
    output logic [LEN_W-1:0] rd_len,
    output logic             op_valid,
    output logic [2:0]       op_kind,
    output logic [6:0]       op_addr,
    output logic             op_rw,
    output logic [7:0]       op_wdata,
    input  logic             op_done,
    input  logic             op_ack,
    input  logic [7:0]       op_rdata,
    output logic [LEN_W-1:0] buf_rd_idx,
    input  logic [7:0]       buf_rd_data,
    output logic             buf_wr_en,
    output logic [LEN_W-1:0] buf_wr_idx,
    output logic [7:0]       buf_wr_data
);

    logic [LEN_W-1:0] wr_count;
    logic [LEN_W-1:0] rx_count;
    logic [LEN_W-1:0] cap;
    logic             rd_clr;
    logic             rd_wr_en;
    logic             rd_idx;

    smbus_seq_len #(.MAX_BLK(MAX_BLK), .LEN_W(LEN_W)) u_len (
        .req_len  (req_len),
        .cap      (cap),
        .rx_byte  (op_rdata),
        .wr_count (wr_count),
        .rx_count (rx_count)
    );

    smbus_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_cmd       (req_cmd),
        .req_addr      (req_addr),
        .req_rw        (req_rw),
        .req_code      (req_code),
        .req_wdata     (req_wdata),
        .req_len       (req_len),
        .req_len_byte  (req_len_byte),
        .req_cmd_phase (req_cmd_phase),
        .wr_count      (wr_count),
        .rx_count      (rx_count),
        .cap           (cap),
        .busy          (busy),
        .done          (done),
        .fail          (fail),
        .rd_len        (rd_len),
        .rd_clr        (rd_clr),
        .rd_wr_en      (rd_wr_en),
        .rd_idx        (rd_idx),
        .op_valid      (op_valid),
        .op_kind       (op_kind),
        .op_addr       (op_addr),
        .op_rw         (op_rw),
        .op_wdata      (op_wdata),
        .op_done       (op_done),
        .op_ack        (op_ack),
        .op_rdata      (op_rdata),
        .buf_rd_idx    (buf_rd_idx),
        .buf_rd_data   (buf_rd_data),
        .buf_wr_en     (buf_wr_en),
        .buf_wr_idx    (buf_wr_idx),
        .buf_wr_data   (buf_wr_data)
    );

    smbus_seq_rdata u_rdata (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rd_clr),
        .wr_en   (rd_wr_en),
        .idx     (rd_idx),
        .byte_in (op_rdata),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/smbus_cmd_seq_chk.sv
// Protocol checker for the sequencer's handshakes, bound to the top.
// Assumes: synchronous active-low reset on rst_n.
module smbus_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       busy,
    input logic       done,
    input logic       op_valid,
    input logic [2:0] op_kind,
    input logic       op_rw,
    input logic [7:0] op_wdata,
    input logic       op_done,
    input logic       buf_wr_en
);

    // done never lasts two cycles.
    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // busy rises only after a request was presented.
    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // No primitive is requested while idle.
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !op_valid);

    // A pending primitive keeps its fields until completed.
    assert_op_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_done) |=> (op_valid && $stable(op_kind) &&
                                    $stable(op_rw) && $stable(op_wdata)));

    // Only the five defined primitive codes appear.
    assert_kind_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_kind <= 3'd4));

    // Buffer writes happen only on a completing receive.
    assert_buf_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> (op_done && op_valid && op_kind == 3'd2));

endmodule

bind smbus_cmd_seq smbus_cmd_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .op_rw     (op_rw),
    .op_wdata  (op_wdata),
    .op_done   (op_done),
    .buf_wr_en (buf_wr_en)
);

// File: tb/smbus_cmd_seq_tb.sv
// Self-checking bench: sweeps every command with a small block limit,
// modelling the byte master and comparing the primitive log.
module smbus_cmd_seq_tb;

    localparam int MAX_BLK = 4;
    localparam int LEN_W   = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [3:0]       req_cmd = '0;
    logic [6:0]       req_addr = '0;
    logic             req_rw = 1'b0;
    logic [7:0]       req_code = '0;
    logic [15:0]      req_wdata = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             req_len_byte = 1'b0;
    logic             req_cmd_phase = 1'b0;
    logic             busy, done, fail;
    logic [15:0]      rd_data;
    logic [LEN_W-1:0] rd_len;
    logic             op_valid;
    logic [2:0]       op_kind;
    logic [6:0]       op_addr;
    logic             op_rw;
    logic [7:0]       op_wdata;
    logic             op_done = 1'b0;
    logic             op_ack = 1'b0;
    logic [7:0]       op_rdata = '0;
    logic [LEN_W-1:0] buf_rd_idx;
    logic [7:0]       buf_rd_data;
    logic             buf_wr_en;
    logic [LEN_W-1:0] buf_wr_idx;
    logic [7:0]       buf_wr_data;

    logic [11:0] log_mem [0:63];
    logic [11:0] exp_mem [0:63];
    logic [7:0]  rx_script [0:15];
    logic [7:0]  wbuf [0:7];
    logic [7:0]  rbuf [0:7];
    integer n_log = 0, n_exp = 0, start_cnt = 0, rx_cnt = 0;
    logic   ack_first = 1'b1, ack_second = 1'b1;
    integer n_checks = 0, n_fail = 0;

    assign buf_rd_data = wbuf[buf_rd_idx];

    smbus_cmd_seq #(.MAX_BLK(MAX_BLK)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_rw(req_rw), .req_code(req_code),
        .req_wdata(req_wdata), .req_len(req_len), .req_len_byte(req_len_byte),
        .req_cmd_phase(req_cmd_phase), .busy(busy), .done(done), .fail(fail),
        .rd_data(rd_data), .rd_len(rd_len), .op_valid(op_valid),
        .op_kind(op_kind), .op_addr(op_addr), .op_rw(op_rw),
        .op_wdata(op_wdata), .op_done(op_done), .op_ack(op_ack),
        .op_rdata(op_rdata), .buf_rd_idx(buf_rd_idx),
        .buf_rd_data(buf_rd_data), .buf_wr_en(buf_wr_en),
        .buf_wr_idx(buf_wr_idx), .buf_wr_data(buf_wr_data)
    );

    // 125 MHz clock.
    initial forever #4 clk = ~clk;

    // Byte master model: one-cycle completion, logs each primitive.
    initial begin
        forever begin
            @(posedge clk);
            if (buf_wr_en) rbuf[buf_wr_idx] <= buf_wr_data;
            if (op_done) begin
                op_done <= 1'b0;
            end else if (op_valid) begin
                op_done  <= 1'b1;
                op_ack   <= 1'b1;
                op_rdata <= 8'h00;
                case (op_kind)
                    3'd0: begin
                        if (n_log < 64) log_mem[n_log] <= {3'd0, op_rw, 1'b0, op_addr};
                        op_ack    <= (start_cnt == 0) ? ack_first : ack_second;
                        start_cnt <= start_cnt + 1;
                    end
                    3'd1: if (n_log < 64) log_mem[n_log] <= {3'd1, 1'b0, op_wdata};
                    3'd2: begin
                        if (n_log < 64) log_mem[n_log] <= {3'd2, 1'b0, 8'h00};
                        op_rdata <= rx_script[rx_cnt[3:0]];
                        rx_cnt   <= rx_cnt + 1;
                    end
                    default: if (n_log < 64) log_mem[n_log] <= {op_kind, 1'b0, 8'h00};
                endcase
                n_log <= n_log + 1;
            end
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail = n_fail + 1;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input integer act, input integer expv);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(input [2:0] k, input r, input [7:0] d);
        exp_mem[n_exp] = {k, r, d};
        n_exp = n_exp + 1;
    endtask

    // Runs one request and compares everything observable.
    task automatic run(input [3:0] cmd, input [6:0] addr, input rw,
                       input [7:0] code, input [15:0] wd, input [2:0] len,
                       input lflag, input cph, input a1, input a2,
                       input intrude);
        string  tag;
        bit     first_read, first_rw, exp_fail, got;
        integer wcnt, n, off;
        logic [15:0] exp_rd;
        logic        act_fail;
        logic [15:0] act_rd;
        logic [2:0]  act_len;
        case (cmd)
            4'd0: tag = "R3";
            4'd1: tag = "R5";
            4'd2: tag = "R6";
            4'd3, 4'd5: tag = "R7";
            4'd4, 4'd6: tag = "R8";
            4'd7: tag = "R10";
            default: tag = "R11";
        endcase
        n_exp = 0; exp_fail = 0; n = 0; off = 0; exp_rd = 16'h0000;
        wcnt = (len > MAX_BLK) ? MAX_BLK : len;
        first_read = (cmd == 4'd2) || (cmd == 4'd8 && !cph);
        first_rw   = (cmd == 4'd0) ? rw : first_read;
        push(3'd0, first_rw, {1'b0, addr});
        if (!a1) begin
            exp_fail = 1;
        end else if (cmd == 4'd0) begin
            push(3'd4, 1'b0, 8'h00);
        end else begin
            bit do_read;
            do_read = first_read;
            if (!first_read) begin
                push(3'd1, 1'b0, code);
                case (cmd)
                    4'd3: push(3'd1, 1'b0, wd[7:0]);
                    4'd5: begin push(3'd1, 1'b0, wd[7:0]); push(3'd1, 1'b0, wd[15:8]); end
                    4'd7: begin
                        if (lflag) push(3'd1, 1'b0, 8'(wcnt));
                        for (int i = 0; i < wcnt; i++) push(3'd1, 1'b0, wbuf[i]);
                    end
                    default: ;
                endcase
                if (cmd == 4'd4 || cmd == 4'd6 || cmd == 4'd8) begin
                    push(3'd0, 1'b1, {1'b0, addr});
                    if (!a2) exp_fail = 1; else do_read = 1;
                end
            end
            if (do_read) begin
                if (cmd == 4'd6) n = 2;
                else if (cmd == 4'd8) begin
                    if (lflag) begin
                        push(3'd2, 1'b0, 8'h00);
                        off = 1;
                        n = (rx_script[0] > len) ? 0 : rx_script[0];
                    end else n = len;
                end else n = 1;
                for (int i = 0; i < n; i++) push(3'd2, 1'b0, 8'h00);
                push(3'd3, 1'b0, 8'h00);
                if (cmd == 4'd2 || cmd == 4'd4) exp_rd = {8'h00, rx_script[0]};
                if (cmd == 4'd6) exp_rd = {rx_script[1], rx_script[0]};
            end
            push(3'd4, 1'b0, 8'h00);
        end

        for (int i = 0; i < 8; i++) rbuf[i] = 8'hEE;
        @(negedge clk);
        n_log = 0; start_cnt = 0; rx_cnt = 0;
        ack_first = a1; ack_second = a2;
        req_cmd = cmd; req_addr = addr; req_rw = rw; req_code = code;
        req_wdata = wd; req_len = len; req_len_byte = lflag; req_cmd_phase = cph;
        req_valid = 1'b1;
        got = 0; act_fail = 0; act_rd = 0; act_len = 0;
        for (int w = 0; w < 300 && !got; w++) begin
            @(negedge clk);
            if (w == 1 && intrude) begin
                req_valid = 1'b1; req_cmd = 4'd0; req_addr = 7'h7F; req_rw = ~rw;
            end else begin
                req_valid = 1'b0;
            end
            if (done) begin
                got = 1; act_fail = fail; act_rd = rd_data; act_len = rd_len;
            end
        end
        req_valid = 1'b0;
        check(got, "R1", "done seen", got, 1);
        check(act_fail == exp_fail, exp_fail ? (a1 ? "R9" : "R4") : tag,
              "fail", act_fail, exp_fail);
        check(n_log == n_exp, intrude ? "R1" : tag, "op count", n_log, n_exp);
        for (int i = 0; i < n_exp && i < n_log; i++)
            check(log_mem[i] == exp_mem[i], tag, "R2 op entry", log_mem[i], exp_mem[i]);
        check(act_rd == exp_rd, tag, "rd_data", act_rd, exp_rd);
        check(int'(act_len) == n, (cmd == 4'd8) ? "R12" : tag, "rd_len", act_len, n);
        if (cmd == 4'd8) begin
            for (int i = 0; i < 8; i++)
                check(rbuf[i] == ((i < n) ? rx_script[off + i] : 8'hEE), "R12",
                      "buffer byte", rbuf[i], (i < n) ? rx_script[off + i] : 8'hEE);
        end
        @(negedge clk);
        check(!busy && !done, "R1", "idle after done", {busy, done}, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin wbuf[i] = 8'hA0 + 8'(i * 7); rbuf[i] = 8'hEE; end
        for (int i = 0; i < 16; i++) rx_script[i] = 8'h31 + 8'(i * 13);
        repeat (3) @(negedge clk);
        check(!busy && !done && !op_valid && !fail, "R1", "reset state",
              {busy, done, op_valid, fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Quick, both directions and both acknowledge outcomes.
        for (int r = 0; r < 2; r++)
            for (int a = 0; a < 2; a++)
                run(4'd0, 7'h21 + 7'(r), r[0], 8'h00, 16'h0, 3'd0, 0, 0, a[0], 1, 0);
        // Send byte, receive byte, byte/word writes.
        for (int a = 0; a < 2; a++) begin
            run(4'd1, 7'h30, 0, 8'h5A, 16'h0, 3'd0, 0, 0, a[0], 1, 0);
            run(4'd2, 7'h31, 0, 8'h00, 16'h0, 3'd0, 0, 0, a[0], 1, 0);
            run(4'd3, 7'h32, 0, 8'hC3, 16'hBEEF, 3'd0, 0, 0, a[0], 1, 0);
            run(4'd5, 7'h33, 0, 8'h3C, 16'h1234, 3'd0, 0, 0, a[0], 1, 0);
        end
        // Byte/word reads with every acknowledge pattern.
        for (int a = 0; a < 4; a++) begin
            run(4'd4, 7'h40, 0, 8'h11, 16'h0, 3'd0, 0, 0, a[0], a[1], 0);
            run(4'd6, 7'h41, 0, 8'h12, 16'h0, 3'd0, 0, 0, a[0], a[1], 0);
        end
        // A second request while busy must not disturb the first.
        run(4'd5, 7'h45, 0, 8'h77, 16'hA55A, 3'd0, 0, 0, 1, 1, 1);
        // Block write: every length, with and without a count byte.
        for (int l = 0; l < 8; l++)
            for (int f = 0; f < 2; f++)
                run(4'd7, 7'h50, 0, 8'h90, 16'h0, 3'(l), f[0], 0, 1, 1, 0);
        run(4'd7, 7'h50, 0, 8'h90, 16'h0, 3'd3, 1, 0, 0, 1, 0);
        // Block read: caller count, both command phase choices.
        for (int l = 0; l < 8; l++)
            for (int c = 0; c < 2; c++)
                run(4'd8, 7'h60, 0, 8'hA1, 16'h0, 3'(l), 0, c[0], 1, 1, 0);
        // Block read: received count against every capacity.
        for (int l = 0; l < 8; l++)
            for (int r = 0; r < 8; r++)
                for (int c = 0; c < 2; c++) begin
                    rx_script[0] = 8'(r);
                    run(4'd8, 7'h61, 0, 8'hA2, 16'h0, 3'(l), 1, c[0], 1, 1, 0);
                end
        rx_script[0] = 8'd200;
        run(4'd8, 7'h62, 0, 8'hA3, 16'h0, 3'd7, 1, 1, 1, 1, 0);
        // Block read acknowledge failures.
        run(4'd8, 7'h63, 0, 8'hA4, 16'h0, 3'd2, 0, 0, 0, 1, 0);
        run(4'd8, 7'h63, 0, 8'hA4, 16'h0, 3'd2, 0, 1, 0, 1, 0);
        run(4'd8, 7'h63, 0, 8'hA4, 16'h0, 3'd2, 0, 1, 1, 0, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule